// File: doc/BRIEF.md
# Printer Port Register Block with Emulated Handshake

This block is the host-side register face of a byte-wide printer port. A simple synchronous bus gives an address, a write strobe, a read strobe and a byte of write data. Behind it sit three registers: an outgoing data latch, a status register and a control register. The printer handshake is emulated inside the block. No pin timing and no printer are modelled.

Software sends a byte by writing it to the data latch. It then toggles the strobe bit of the control register from low to high while select and init are high. That rising strobe puts the latched byte on an output byte bus with a one-cycle valid pulse, and it drops busy in status. Each later status read steps the acknowledge and busy bits through their idle sequence. Each status read also clears a pending-interrupt flag. A level interrupt output follows that flag. The flag is raised by a control write that has select high and strobe low, but only when the control value stored before that write had interrupt enable set.

Top module: `pport_regs`

## Requirements
- R1: Only the low three address bits are decoded, so upper address bits have no effect. Offset 0 is data, offset 1 is status and offset 2 is control. A read of offsets 3 to 7 returns 0xFF.
- R2: After reset the written data latch reads 0xFF, status reads 0xD9 and control reads 0xCC. irq and out_valid are low.
- R3: Every control write stores the written byte with bits 7 and 6 forced to one. A control read returns that stored value.
- R4: A control write with init (bit 2) at zero loads status with 0xD8. This takes priority over the select and strobe handling, so nothing is emitted.
- R5: A control write with init and select (bit 3) set and strobe (bit 0) set clears busy (status bit 7). If the previously stored strobe bit was zero, out_byte carries the data latch and out_valid is high for exactly the one cycle after the write.
- R6: A control write with init and select set and strobe clear raises the pending flag if interrupt enable (bit 4) was set in the control value stored before the write. The enable bit of the value being written does not count.
- R7: irq is a level equal to the pending flag. Only a status read clears it; other writes leave it set.
- R8: A data read returns the written latch when direction (control bit 5) is clear. When direction is set it returns the read-back latch, which holds 0xFF.
- R9: A status read returns status as it was before the read. After the read, if busy and the stored strobe are both zero: when ack (bit 6) is set it is cleared, and when ack is clear both ack and busy are set. Otherwise status does not change.
- R10: Read data appears on bus_rdata in the cycle after the read strobe and holds until the next read. Writes to status or to offsets 3 to 7 change no state.
- R11: When bus_wr and bus_rd are high in the same cycle, the write is performed and the read is ignored. bus_rdata keeps its value and no read side effect occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address; the low three bits are decoded |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| out_byte | output | 8 | Byte emitted by a strobe edge |
| out_valid | output | 1 | One-cycle qualifier for out_byte |
| irq | output | 1 | Level interrupt following the pending flag |

## Verification
The hardest state to reach is the acknowledge walk. It starts only when busy has been dropped by a strobe and strobe has since been written back low. Reaching it takes the following sequence:
1. Reset.
2. A control write with init low, which loads 0xD8.
3. A rising strobe, which emits a byte and clears busy.
4. A repeated strobe-high write, which must not emit.
5. A strobe-low write.

Only then do three status reads return 0x58, 0x18 and 0xD8 in turn. The stimulus also separates the interrupt enable bit of the stored control value from the one being written. It does this with pairs of identical and differing control writes.

// File: rtl/pport_pkg.sv
package pport_pkg;

   localparam int unsigned DEC_W = 3;

   localparam logic [DEC_W-1:0] OFS_DATA = 3'd0;
   localparam logic [DEC_W-1:0] OFS_STAT = 3'd1;
   localparam logic [DEC_W-1:0] OFS_CTL  = 3'd2;

   localparam int unsigned CB_STROBE = 0;
   localparam int unsigned CB_INIT   = 2;
   localparam int unsigned CB_SELECT = 3;
   localparam int unsigned CB_IRQEN  = 4;
   localparam int unsigned CB_DIR    = 5;

   localparam int unsigned SB_BUSY = 7;
   localparam int unsigned SB_ACK  = 6;

   localparam logic [7:0] STAT_RESET = 8'hD9;
   localparam logic [7:0] STAT_INIT  = 8'hD8;
   localparam logic [7:0] CTL_RESET  = 8'hCC;
   localparam logic [7:0] CTL_FORCE  = 8'hC0;
   localparam logic [7:0] BYTE_IDLE  = 8'hFF;

   typedef struct packed {
      logic data;
      logic stat;
      logic ctl;
   } pp_sel_t;

endpackage

// File: rtl/pport_decode.sv
module pport_decode
   import pport_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output pp_sel_t           wsel,
   output pp_sel_t           rsel,
   output logic              rd_fire
);

   logic [DEC_W-1:0] ofs;
   pp_sel_t          hit;

   generate
      if (ADDR_W < DEC_W) begin : g_bad_width
         $error("pport_decode: ADDR_W must be at least 3");
      end else if (ADDR_W > DEC_W) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:DEC_W];
         assign ofs = addr[DEC_W-1:0];
      end else begin : g_exact
         assign ofs = addr;
      end
   endgenerate

   always_comb begin
      hit = '0;
      case (ofs)
         OFS_DATA: hit.data = 1'b1;
         OFS_STAT: hit.stat = 1'b1;
         OFS_CTL:  hit.ctl  = 1'b1;
         default:  hit      = '0;
      endcase
   end

   // write wins over a simultaneous read (R11)
   assign rd_fire   = rd & ~wr;
   assign wsel.data = wr & hit.data;
   assign wsel.stat = 1'b0;
   assign wsel.ctl  = wr & hit.ctl;
   assign rsel.data = rd_fire & hit.data;
   assign rsel.stat = rd_fire & hit.stat;
   assign rsel.ctl  = rd_fire & hit.ctl;

endmodule

// File: rtl/pport_hshake.sv
module pport_hshake
   import pport_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  pp_sel_t    wsel,
   input  pp_sel_t    rsel,
   input  logic [7:0] wdata,
   output logic [7:0] data_w,
   output logic [7:0] stat_q,
   output logic [7:0] ctl_q,
   output logic       irq,
   output logic [7:0] out_byte,
   output logic       out_valid
);

   logic [7:0] ctl_nx;
   logic       pend_q;
   logic       walk_en;

   assign ctl_nx  = wdata | CTL_FORCE;
   assign walk_en = ~stat_q[SB_BUSY] & ~ctl_q[CB_STROBE];
   assign irq     = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_w    <= BYTE_IDLE;
         stat_q    <= STAT_RESET;
         ctl_q     <= CTL_RESET;
         pend_q    <= 1'b0;
         out_byte  <= BYTE_IDLE;
         out_valid <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         if (wsel.data) begin
            data_w <= wdata;
         end
         if (wsel.ctl) begin
            if (!ctl_nx[CB_INIT]) begin
               stat_q <= STAT_INIT;
            end else if (ctl_nx[CB_SELECT]) begin
               if (ctl_nx[CB_STROBE]) begin
                  stat_q[SB_BUSY] <= 1'b0;
                  if (!ctl_q[CB_STROBE]) begin
                     out_valid <= 1'b1;
                     out_byte  <= data_w;
                  end
               end else if (ctl_q[CB_IRQEN]) begin
                  pend_q <= 1'b1;
               end
            end
            ctl_q <= ctl_nx;
         end else if (rsel.stat) begin
            pend_q <= 1'b0;
            if (walk_en) begin
               if (stat_q[SB_ACK]) begin
                  stat_q[SB_ACK] <= 1'b0;
               end else begin
                  stat_q[SB_ACK]  <= 1'b1;
                  stat_q[SB_BUSY] <= 1'b1;
               end
            end
         end
      end
   end

   a_r4_init_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wsel.ctl && !wdata[CB_INIT]) |=> (stat_q == STAT_INIT));

   a_r4_no_emit: assert property (@(posedge clk) disable iff (!rst_n)
      (wsel.ctl && !wdata[CB_INIT]) |=> !out_valid);

   a_r5_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wsel.ctl && wdata[CB_INIT] && wdata[CB_SELECT] && wdata[CB_STROBE]) |=> !stat_q[SB_BUSY]);

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   a_r5_strobe_high: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ctl_q[CB_STROBE]);

   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rsel.stat |=> !irq);

   a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ctl_q[CB_IRQEN]));

endmodule

// File: rtl/pport_rdmux.sv
module pport_rdmux
   import pport_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_fire,
   input  pp_sel_t    rsel,
   input  logic [7:0] data_w,
   input  logic [7:0] stat_q,
   input  logic [7:0] ctl_q,
   output logic [7:0] rdata
);

   localparam logic [7:0] READBACK = BYTE_IDLE;

   logic [7:0] rd_nx;

   always_comb begin
      rd_nx = BYTE_IDLE;
      if (rsel.data) begin
         rd_nx = ctl_q[CB_DIR] ? READBACK : data_w;
      end else if (rsel.stat) begin
         rd_nx = stat_q;
      end else if (rsel.ctl) begin
         rd_nx = ctl_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= BYTE_IDLE;
      end else if (rd_fire) begin
         rdata <= rd_nx;
      end
   end

   a_r1_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && !(|rsel)) |=> (rdata == BYTE_IDLE));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_fire |=> $stable(rdata));

   a_r3_ctl_forced: assert property (@(posedge clk) disable iff (!rst_n)
      rsel.ctl |=> (rdata[7:6] == 2'b11));

endmodule

// File: rtl/pport_regs.sv
module pport_regs
   import pport_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic [7:0]        out_byte,
   output logic              out_valid,
   output logic              irq
);

   pp_sel_t    wsel;
   pp_sel_t    rsel;
   logic       rd_fire;
   logic [7:0] data_w;
   logic [7:0] stat_q;
   logic [7:0] ctl_q;

   pport_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr    (bus_addr),
      .wr      (bus_wr),
      .rd      (bus_rd),
      .wsel    (wsel),
      .rsel    (rsel),
      .rd_fire (rd_fire)
   );

   pport_hshake u_hshake (
      .clk       (clk),
      .rst_n     (rst_n),
      .wsel      (wsel),
      .rsel      (rsel),
      .wdata     (bus_wdata),
      .data_w    (data_w),
      .stat_q    (stat_q),
      .ctl_q     (ctl_q),
      .irq       (irq),
      .out_byte  (out_byte),
      .out_valid (out_valid)
   );

   pport_rdmux u_rdmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_fire (rd_fire),
      .rsel    (rsel),
      .data_w  (data_w),
      .stat_q  (stat_q),
      .ctl_q   (ctl_q),
      .rdata   (bus_rdata)
   );

   a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_rd) |=> $stable(bus_rdata));

endmodule

// File: tb/pport_regs_bench.sv
module pport_regs_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] out_byte;
   logic       out_valid;
   logic       irq;

   int n_cmp = 0;
   int n_bad = 0;
   logic rd_seen = 1'b0;

   logic [7:0] exp_rd_q[$];
   string      tag_rd_q[$];
   logic [7:0] exp_byte_q[$];

   always #4 clk = ~clk;

   pport_regs #(.ADDR_W(4)) u_pport_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .out_byte  (out_byte),
      .out_valid (out_valid),
      .irq       (irq)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic do_emit(input logic [3:0] a, input logic [7:0] d, input logic [7:0] b);
      exp_byte_q.push_back(b);
      do_wr(a, d);
   endtask

   task automatic do_rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
      exp_rd_q.push_back(exp);
      tag_rd_q.push_back(tag);
      bus_addr = a;
      bus_rd   = 1'b1;
      @(negedge clk);
      bus_rd   = 1'b0;
   endtask

   always @(posedge clk) rd_seen <= bus_rd && !bus_wr && rst_n;

   // monitor: read results and emitted bytes
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_rd_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R10 actual=%02h expected=no read", bus_rdata);
         end else begin
            chk(tag_rd_q.pop_front(), bus_rdata, exp_rd_q.pop_front());
         end
      end
      if (out_valid) begin
         if (exp_byte_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R5 actual=%02h expected=no byte", out_byte);
         end else begin
            chk("R5 byte", out_byte, exp_byte_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R2 irq", {7'd0, irq}, 8'h00);
      chk("R2 out_valid", {7'd0, out_valid}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      do_rd(4'h2, 8'hCC, "R2 ctl");
      do_rd(4'h1, 8'hD9, "R2 stat");
      do_rd(4'h0, 8'hFF, "R2 data");
      do_rd(4'h3, 8'hFF, "R1 ofs3");
      do_rd(4'h7, 8'hFF, "R1 ofs7");
      do_rd(4'hA, 8'hCC, "R1 upper bits ctl");
      do_rd(4'h9, 8'hD9, "R1 upper bits stat");

      do_wr(4'h0, 8'h5A);
      do_rd(4'h0, 8'h5A, "R8 dir clear");
      do_wr(4'h2, 8'h2C);
      do_rd(4'h0, 8'hFF, "R8 dir set");
      do_rd(4'h2, 8'hEC, "R3 forced bits");

      do_wr(4'h2, 8'h00);
      do_rd(4'h1, 8'hD8, "R4 init load");
      do_rd(4'h2, 8'hC0, "R3 zero write");

      do_wr(4'h2, 8'h0C);
      do_emit(4'h2, 8'h0D, 8'h5A);
      do_wr(4'h2, 8'h0D);
      do_rd(4'h1, 8'h58, "R5 busy cleared");
      do_rd(4'h1, 8'h58, "R9 strobe high no walk");

      do_wr(4'h2, 8'h0C);
      do_rd(4'h1, 8'h58, "R9 walk step0");
      do_rd(4'h1, 8'h18, "R9 walk ack cleared");
      do_rd(4'h1, 8'hD8, "R9 walk ack busy set");

      do_wr(4'h2, 8'h1C);
      chk("R6 enable in new value only", {7'd0, irq}, 8'h00);
      do_wr(4'h2, 8'h1C);
      chk("R6 pending raised", {7'd0, irq}, 8'h01);
      do_wr(4'h0, 8'h33);
      chk("R7 irq held", {7'd0, irq}, 8'h01);
      do_rd(4'h1, 8'hD8, "R7 stat with irq");
      chk("R7 read clears", {7'd0, irq}, 8'h00);

      do_wr(4'h2, 8'h0C);
      chk("R6 enable from stored value", {7'd0, irq}, 8'h01);
      do_wr(4'h2, 8'h0C);
      chk("R7 irq still held", {7'd0, irq}, 8'h01);
      do_rd(4'h1, 8'hD8, "R7 stat");
      chk("R7 cleared again", {7'd0, irq}, 8'h00);

      do_emit(4'h2, 8'h0D, 8'h33);
      do_wr(4'h0, 8'h77);
      do_wr(4'h2, 8'h0C);
      do_emit(4'h2, 8'h0D, 8'h77);
      do_rd(4'h1, 8'h58, "R5 second emit busy");

      do_wr(4'h2, 8'h0C);
      do_wr(4'h2, 8'h09);
      do_rd(4'h1, 8'hD8, "R4 priority over strobe");

      do_wr(4'h1, 8'h00);
      do_rd(4'h1, 8'hD8, "R10 status write ignored");
      do_wr(4'h5, 8'h00);
      do_rd(4'h0, 8'h77, "R10 ofs5 write ignored data");
      do_rd(4'h2, 8'hC9, "R10 ofs5 write ignored ctl");

      bus_addr  = 4'h0;
      bus_wdata = 8'h11;
      bus_wr    = 1'b1;
      bus_rd    = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      bus_rd = 1'b0;
      chk("R11 read ignored", bus_rdata, 8'hC9);
      @(negedge clk);
      chk("R10 rdata holds", bus_rdata, 8'hC9);
      do_rd(4'h0, 8'h11, "R11 write performed");

      repeat (4) @(negedge clk);
      chk("R5 bytes outstanding", 8'(exp_byte_q.size()), 8'h00);
      chk("R10 reads outstanding", 8'(exp_rd_q.size()), 8'h00);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule